// File: doc/BRIEF.md
# Freezable Data Cache Policy Controller

This block controls a small 4-way set-associative data cache that holds its own tag, state, recency and data arrays. In normal operation it runs copy-back with allocate on miss. A load or store that misses picks a victim way. A modified victim is first written out as a line burst. The line is then filled, and the access completes as a hit.

Two policy inputs are sampled with every request. Under freeze, the cache still serves load hits, but no tag, valid, dirty or recency bit is modified. Load misses become single-word uncached reads, and every store becomes a single-word write-through. A store that hits also patches the cached word. Under debug, the array is not consulted at all: every load and store is a single-word memory access, and nothing in the cache changes.

The core side accepts one request at a time and returns load data with a one-cycle pulse. The memory side is a request/acknowledge port. It carries one word per acknowledge. A flag marks the four beats of a line burst.

Top module: `frz_dcache_ctrl`

## Requirements
- R1: After reset the core side is ready, no memory request and no response is pending, and every way is invalid, so the first access to any line misses.
- R2: In normal mode a load miss fetches its line as four burst reads at word addresses line base + 0, 1, 2, 3 in that order. It returns the requested word. A later load to the same line produces no memory traffic.
- R3: In normal mode a store hit writes the array and marks the line modified without touching memory. A later load returns the stored value, and the stored value reaches memory only when the line is evicted.
- R4: In normal mode a store miss first fills the line with four burst reads, then merges the store data; no write-through is issued.
- R5: On a miss the victim is the lowest-numbered invalid way in the set if there is one. Otherwise it is the least recently used way, where every normal hit, and every completed fill, makes its way the most recently used.
- R6: A modified victim is written out as four burst writes at its own line base + 0..3, ahead of the four fill reads; a clean victim causes no write.
- R7: Under freeze a load hit returns array data with no memory access and leaves the recency order unchanged.
- R8: Under freeze a load miss performs one non-burst read of the requested word and allocates nothing.
- R9: Under freeze every store performs one non-burst write of the requested word. On a hit the cached word takes the new value but the line is not marked modified; on a miss nothing is allocated.
- R10: Under debug every load and store performs one non-burst memory access even when the line is resident, and the array, including the data words, is left unchanged.
- R11: Ready is low from the cycle after acceptance until the access completes, ready and memory request are never high together, and a memory request holds its address and direction until acknowledged.
- R12: A load completes with the response valid high for exactly one cycle, in the cycle ready returns high; stores give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address (offset in low bits, then set index, then tag) |
| req_wdata | input | DATA_W | Store data |
| req_freeze | input | 1 | Freeze policy for this request |
| req_debug | input | 1 | Debug bypass for this request |
| req_ready | output | 1 | Controller idle and accepting |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory transfer requested |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_burst | output | 1 | Beat belongs to a four-word line transfer |
| mem_addr | output | ADDR_W | Word address of the current beat |
| mem_wdata | output | DATA_W | Write data of the current beat |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The hardest situations to reach from the ports are the ones where the effect of a request shows only later, through which line gets evicted. A frozen hit that must not refresh recency, and a frozen store hit that must not mark the line modified, are examples. The bench fills one set with four known lines in a known order and then places the frozen or debug access. It then forces further misses, and reads the victim's identity from whether a reload misses, and whether any write beats show up ahead of the fill. Debug bypass is shown the same way: a debug store changes memory only, so a normal hit afterwards still returns the old array value.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SINGLE,
        ST_WBACK,
        ST_FILL
    } ctl_st_e;

endpackage

// File: rtl/dc_way_match.sv
module dc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tag,
    input  logic [WAYS-1:0]            set_vld,
    input  logic [WAYS-1:0][WAY_W-1:0] set_age,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic [WAY_W-1:0]           victim_way
);

    logic [WAYS-1:0]  match;
    logic             inv_any;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] old_way;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = set_vld[g] && (set_tag[g] == probe_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    // Invalid ways win (lowest index), otherwise the oldest way.
    always_comb begin
        inv_any = 1'b0;
        inv_way = '0;
        old_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_vld[w]) begin
                inv_any = 1'b1;
                inv_way = WAY_W'(w);
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (set_age[w] == WAY_W'(WAYS - 1)) old_way = WAY_W'(w);
        end
    end

    assign victim_way = inv_any ? inv_way : old_way;

endmodule

// File: rtl/dc_age_touch.sv
module dc_age_touch #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_in,
    input  logic [WAY_W-1:0]           way,
    output logic [WAYS-1:0][WAY_W-1:0] age_out
);

    // Touched way becomes age 0; younger ways age by one.
    for (genvar g = 0; g < WAYS; g++) begin : g_age
        assign age_out[g] = (WAY_W'(g) == way)         ? '0 :
                            (age_in[g] < age_in[way])  ? age_in[g] + WAY_W'(1) :
                                                         age_in[g];
    end

endmodule

// File: rtl/frz_dcache_ctrl.sv
module frz_dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_freeze,
    input  logic              req_debug,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int META_W = SETS * WAYS * (TAG_W + 2 + WAY_W);

    typedef struct packed {
        ctl_st_e                                         st;
        logic [ADDR_W-1:0]                               addr;
        logic                                            we;
        logic [DATA_W-1:0]                               wdata;
        logic                                            frz;
        logic                                            dbg;
        logic [WAY_W-1:0]                                vic;
        logic [OFF_W-1:0]                                cnt;
        logic                                            rsp_v;
        logic [DATA_W-1:0]                               rsp_d;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]            tag;
        logic [SETS-1:0][WAYS-1:0]                       vld;
        logic [SETS-1:0][WAYS-1:0]                       dirty;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]            age;
        logic [SETS-1:0][WAYS-1:0][LINE_WORDS-1:0][DATA_W-1:0] data;
    } ctl_t;

    function automatic ctl_t init_state();
        ctl_t s;
        s    = '0;
        s.st = ST_IDLE;
        for (int si = 0; si < SETS; si++) begin
            for (int w = 0; w < WAYS; w++) begin
                s.age[si][w] = WAY_W'(w);
            end
        end
        return s;
    endfunction

    ctl_t q, d;

    logic [IDX_W-1:0]           idx;
    logic [OFF_W-1:0]           off;
    logic [TAG_W-1:0]           ptag;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           victim_way;
    logic [WAYS-1:0][WAY_W-1:0] touched_age;
    logic [META_W-1:0]          meta_bits;
    logic                       last_beat;

    assign idx       = q.addr[OFF_W +: IDX_W];
    assign off       = q.addr[OFF_W-1:0];
    assign ptag      = q.addr[ADDR_W-1 -: TAG_W];
    assign last_beat = (q.cnt == OFF_W'(LINE_WORDS - 1));
    assign meta_bits = {q.tag, q.vld, q.dirty, q.age};

    dc_way_match #(
        .WAYS (WAYS),
        .TAG_W(TAG_W),
        .WAY_W(WAY_W)
    ) u_match (
        .set_tag   (q.tag[idx]),
        .set_vld   (q.vld[idx]),
        .set_age   (q.age[idx]),
        .probe_tag (ptag),
        .hit       (hit),
        .hit_way   (hit_way),
        .victim_way(victim_way)
    );

    dc_age_touch #(
        .WAYS (WAYS),
        .WAY_W(WAY_W)
    ) u_age (
        .age_in (q.age[idx]),
        .way    (hit_way),
        .age_out(touched_age)
    );

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.we    = req_write;
                    d.wdata = req_wdata;
                    d.frz   = req_freeze | req_debug;
                    d.dbg   = req_debug;
                    d.st    = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (q.dbg) begin
                    d.st = ST_SINGLE;
                end else if (q.frz) begin
                    if (hit && !q.we) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = q.data[idx][hit_way][off];
                        d.st    = ST_IDLE;
                    end else begin
                        if (hit) d.data[idx][hit_way][off] = q.wdata;
                        d.st = ST_SINGLE;
                    end
                end else if (hit) begin
                    d.age[idx] = touched_age;
                    if (q.we) begin
                        d.data[idx][hit_way][off] = q.wdata;
                        d.dirty[idx][hit_way]     = 1'b1;
                    end else begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = q.data[idx][hit_way][off];
                    end
                    d.st = ST_IDLE;
                end else begin
                    d.vic = victim_way;
                    d.cnt = '0;
                    d.st  = (q.vld[idx][victim_way] && q.dirty[idx][victim_way])
                            ? ST_WBACK : ST_FILL;
                end
            end
            ST_SINGLE: begin
                if (mem_ack) begin
                    if (!q.we) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = mem_rdata;
                    end
                    d.st = ST_IDLE;
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    d.cnt = q.cnt + OFF_W'(1);
                    if (last_beat) d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    d.data[idx][q.vic][q.cnt] = mem_rdata;
                    d.cnt = q.cnt + OFF_W'(1);
                    if (last_beat) begin
                        d.tag[idx][q.vic]   = ptag;
                        d.vld[idx][q.vic]   = 1'b1;
                        d.dirty[idx][q.vic] = 1'b0;
                        d.st                = ST_LOOKUP;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= init_state();
        else        q <= d;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rsp_d;
    assign mem_req   = (q.st == ST_SINGLE) || (q.st == ST_WBACK) || (q.st == ST_FILL);
    assign mem_burst = (q.st == ST_WBACK) || (q.st == ST_FILL);
    assign mem_write = (q.st == ST_WBACK) || ((q.st == ST_SINGLE) && q.we);

    always_comb begin
        unique case (q.st)
            ST_WBACK: mem_addr = {q.tag[idx][q.vic], idx, q.cnt};
            ST_FILL:  mem_addr = {ptag, idx, q.cnt};
            default:  mem_addr = q.addr;
        endcase
        mem_wdata = (q.st == ST_WBACK) ? q.data[idx][q.vic][q.cnt] : q.wdata;
    end

endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
    parameter int ADDR_W = 16,
    parameter int META_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic              mem_write,
    input logic              mem_burst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              frz_mode,
    input logic              dbg_mode,
    input logic [META_W-1:0] meta
);

    // R11
    ready_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mem_req));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));

    // R7
    frozen_meta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && frz_mode) |=> $stable(meta));

    // R8
    frozen_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && frz_mode) |-> !mem_burst);

    // R10
    debug_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && dbg_mode) |-> !mem_burst);

    // R12
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

endmodule

bind frz_dcache_ctrl dcache_chk #(
    .ADDR_W(ADDR_W),
    .META_W(META_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_req  (mem_req),
    .mem_write(mem_write),
    .mem_burst(mem_burst),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .frz_mode (q.frz),
    .dbg_mode (q.dbg),
    .meta     (meta_bits)
);

// File: tb/tb_frz_dcache_ctrl.sv
module tb_frz_dcache_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_freeze = 1'b0;
    logic        req_debug = 1'b0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req;
    logic        mem_write;
    logic        mem_burst;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    int overlap = 0;
    int early_ready = 0;

    logic [31:0] wmem [logic [15:0]];
    logic [15:0] lg_addr [$];
    bit          lg_we [$];
    bit          lg_burst [$];
    logic [31:0] lg_data [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    frz_dcache_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_freeze(req_freeze), .req_debug(req_debug),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_burst(mem_burst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mdat(input logic [15:0] a);
        if (wmem.exists(a)) return wmem[a];
        return 32'h5A00_0000 | {16'h0, a};
    endfunction

    // Memory model: acknowledges every other cycle, logs each beat.
    always @(negedge clk) begin
        if (mem_req && req_ready) overlap++;
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req && rst_n) begin
            lg_addr.push_back(mem_addr);
            lg_we.push_back(mem_write);
            lg_burst.push_back(mem_burst);
            lg_data.push_back(mem_wdata);
            if (mem_write) wmem[mem_addr] = mem_wdata;
            else           mem_rdata <= mdat(mem_addr);
            mem_ack <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, what, act, exp);
    endtask

    task automatic access(input bit we, input logic [15:0] a, input logic [31:0] wd,
                          input bit frz, input bit dbg,
                          output logic [31:0] rd, output int nrsp);
        lg_addr.delete(); lg_we.delete(); lg_burst.delete(); lg_data.delete();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
        req_freeze = frz;  req_debug = dbg;
        @(negedge clk);
        req_valid = 1'b0; req_freeze = 1'b0; req_debug = 1'b0;
        if (req_ready) early_ready++;
        nrsp = 0;
        rd   = '0;
        for (int i = 0; i < 400; i++) begin
            if (rsp_valid) begin
                nrsp++;
                rd = rsp_rdata;
            end
            if (req_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic ops(input string tag, input int er, input int ew);
        int nr = 0;
        int nw = 0;
        foreach (lg_we[i]) begin
            if (lg_we[i]) nw++;
            else          nr++;
        end
        check_eq(tag, "read beats", nr, er);
        check_eq(tag, "write beats", nw, ew);
    endtask

    task automatic line_order(input string tag, input int start,
                              input logic [15:0] base, input bit we);
        for (int i = 0; i < 4; i++) begin
            bit ok;
            ok = (lg_addr.size() > start + i) && lg_addr[start+i] == base + 16'(i)
                 && lg_we[start+i] == we && lg_burst[start+i];
            check(ok, tag, "burst beat address",
                  (lg_addr.size() > start + i) ? {16'h0, lg_addr[start+i]} : 32'hFFFF_FFFF,
                  {16'h0, base + 16'(i)});
        end
    endtask

    task automatic single(input string tag, input logic [15:0] a, input bit we);
        bit ok;
        ok = lg_addr.size() == 1 && lg_addr[0] == a && lg_we[0] == we && !lg_burst[0];
        check(ok, tag, "single beat", lg_addr.size() > 0 ? {16'h0, lg_addr[0]} : 32'hFFFF_FFFF,
              {16'h0, a});
    endtask

    // R1
    task automatic t_reset();
        check_eq("R1", "ready after reset", req_ready, 1);
        check_eq("R1", "mem_req after reset", mem_req, 0);
        check_eq("R1", "rsp_valid after reset", rsp_valid, 0);
    endtask

    // R2, R12, R1
    task automatic t_fill();
        logic [31:0] rd; int n;
        access(0, 16'h0106, 0, 0, 0, rd, n);
        ops("R2", 4, 0);
        line_order("R2", 0, 16'h0104, 0);
        check_eq("R2", "miss data", rd, mdat(16'h0106));
        check_eq("R12", "load pulse count", n, 1);
        access(0, 16'h0105, 0, 0, 0, rd, n);
        ops("R2", 0, 0);
        check_eq("R2", "hit data", rd, mdat(16'h0105));
    endtask

    // R3, R12
    task automatic t_store_hit();
        logic [31:0] rd; int n;
        access(1, 16'h0105, 32'hDEAD_0001, 0, 0, rd, n);
        ops("R3", 0, 0);
        check_eq("R12", "store gives no response", n, 0);
        access(0, 16'h0105, 0, 0, 0, rd, n);
        ops("R3", 0, 0);
        check_eq("R3", "stored value", rd, 32'hDEAD_0001);
    endtask

    // R5, R6, R3: set 1 filled in order 010,020,030,040
    task automatic t_lru_wb();
        logic [31:0] rd; int n;
        access(0, 16'h0204, 0, 0, 0, rd, n); ops("R5", 4, 0);
        access(0, 16'h0304, 0, 0, 0, rd, n); ops("R5", 4, 0);
        access(0, 16'h0404, 0, 0, 0, rd, n); ops("R5", 4, 0);
        access(0, 16'h0104, 0, 0, 0, rd, n); ops("R5", 0, 0);
        access(0, 16'h0504, 0, 0, 0, rd, n);
        ops("R6", 4, 0);
        access(0, 16'h0204, 0, 0, 0, rd, n);
        ops("R5", 4, 0);
        access(0, 16'h0604, 0, 0, 0, rd, n);
        ops("R5", 4, 0);
        access(0, 16'h0704, 0, 0, 0, rd, n);
        ops("R6", 4, 4);
        line_order("R6", 0, 16'h0104, 1);
        line_order("R6", 4, 16'h0704, 0);
        check_eq("R3", "written-back modified word", lg_data[1], 32'hDEAD_0001);
        check_eq("R6", "written-back clean word", lg_data[0], 32'h5A00_0104);
        check_eq("R2", "data after write-back fill", rd, mdat(16'h0704));
    endtask

    // R7, R8: set 2
    task automatic t_freeze_load();
        logic [31:0] rd; int n;
        access(0, 16'h0208, 0, 0, 0, rd, n);
        access(0, 16'h0209, 0, 1, 0, rd, n);
        ops("R7", 0, 0);
        check_eq("R7", "frozen hit data", rd, mdat(16'h0209));
        access(0, 16'h0308, 0, 0, 0, rd, n);
        access(0, 16'h0408, 0, 0, 0, rd, n);
        access(0, 16'h0508, 0, 0, 0, rd, n);
        access(0, 16'h020A, 0, 1, 0, rd, n);
        ops("R7", 0, 0);
        access(0, 16'h0608, 0, 0, 0, rd, n);
        ops("R7", 4, 0);
        access(0, 16'h0208, 0, 0, 0, rd, n);
        ops("R7", 4, 0);
        access(0, 16'h0808, 0, 1, 0, rd, n);
        single("R8", 16'h0808, 0);
        check_eq("R8", "frozen miss data", rd, mdat(16'h0808));
        access(0, 16'h0808, 0, 1, 0, rd, n);
        single("R8", 16'h0808, 0);
    endtask

    // R9
    task automatic t_freeze_store();
        logic [31:0] rd; int n;
        access(1, 16'h0209, 32'hBEEF_0002, 1, 0, rd, n);
        single("R9", 16'h0209, 1);
        check_eq("R9", "write-through data", lg_data[0], 32'hBEEF_0002);
        access(0, 16'h0209, 0, 0, 0, rd, n);
        ops("R9", 0, 0);
        check_eq("R9", "cached word patched", rd, 32'hBEEF_0002);
        access(0, 16'h0908, 0, 0, 0, rd, n);
        access(0, 16'h0A08, 0, 0, 0, rd, n);
        access(0, 16'h0B08, 0, 0, 0, rd, n);
        access(0, 16'h0C08, 0, 0, 0, rd, n);
        ops("R9", 4, 0);
        access(1, 16'h0D08, 32'hBEEF_0003, 1, 0, rd, n);
        single("R9", 16'h0D08, 1);
        access(0, 16'h0D08, 0, 0, 0, rd, n);
        ops("R9", 4, 0);
        check_eq("R9", "miss not allocated, memory holds value", rd, 32'hBEEF_0003);
    endtask

    // R10
    task automatic t_debug();
        logic [31:0] rd; int n;
        access(1, 16'h0C09, 32'hC0DE_0004, 0, 1, rd, n);
        single("R10", 16'h0C09, 1);
        access(0, 16'h0C09, 0, 0, 0, rd, n);
        ops("R10", 0, 0);
        check_eq("R10", "array untouched by debug store", rd, 32'h5A00_0C09);
        access(0, 16'h0C09, 0, 0, 1, rd, n);
        single("R10", 16'h0C09, 0);
        check_eq("R10", "debug load from memory", rd, 32'hC0DE_0004);
    endtask

    // R4
    task automatic t_wr_alloc();
        logic [31:0] rd; int n;
        access(1, 16'h0E0C, 32'hFACE_0005, 0, 0, rd, n);
        ops("R4", 4, 0);
        line_order("R4", 0, 16'h0E0C, 0);
        check_eq("R12", "store miss gives no response", n, 0);
        access(0, 16'h0E0C, 0, 0, 0, rd, n);
        ops("R4", 0, 0);
        check_eq("R4", "merged store word", rd, 32'hFACE_0005);
        access(0, 16'h0E0D, 0, 0, 0, rd, n);
        check_eq("R4", "neighbour word from fill", rd, mdat(16'h0E0D));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_store_hit();
        t_lru_wb();
        t_freeze_load();
        t_freeze_store();
        t_debug();
        t_wr_alloc();
        check_eq("R11", "ready with mem_req cycles", overlap, 0);
        check_eq("R11", "ready high right after accept", early_ready, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule